// File: doc/BRIEF.md
# VPS Biphase Line Decoder

This block turns the sliced data of the dedicated VPS video line into a checked payload word for the host. A sampler upstream delivers one data level per half-bit, each with a one-cycle strobe. A timing block marks the start of the line and holds a gate signal high while line 16 is in progress. Each bit cell has two half-bits of opposite level. The decoder pairs the half-bits into bits and tests every cell for a biphase violation. It compares the leading run-in and start code with a fixed pattern and assembles the remaining bits into bytes, earliest bit first.

The transfer word is written only when the whole line has arrived without a single fault. It then takes its content from six chosen line bytes, and every unused position holds a 1. A one-cycle store strobe marks the update, and the active-low data-available output falls at the same moment. That output returns high when the next line 16 begins. The host bus raises an inhibit input while it is reading. If the inhibit is high at the moment a clean line completes, the update is dropped, so the host never sees a word change while it reads.

Top module: `vps_line_decoder`

## Requirements
- R1: After reset (and at every later reset) `davn_n` is 1, `store` is 0 and `payload` is all ones.
- R2: A line is acquired only when `line_start` is pulsed while `line16` is 1. Half-bit strobes that arrive outside such a line have no effect. If `line16` drops before the line is complete, that line is abandoned, and strobes after it are ignored until the next accepted `line_start`.
- R3: The two half-bits of each cell are taken in order. The first half gives the bit value, and the second half must be its complement. If any cell has equal halves, the line produces no store.
- R4: A line has LINE_BYTES (15) bytes, 120 bits in all. The first 24 received bits are checked against SYNC_WORD (default 24'h515555, where bit k is the k-th received bit). Any mismatch suppresses the store.
- R5: When the 120th bit of a line with no faults has been taken, `store` is 1 for exactly one cycle. `davn_n` goes to 0 on that same clock edge. `davn_n` never falls without a store.
- R6: Line byte n (counted from 1) is made of received bits 8(n-1) to 8n-1, with its bit 0 received first. Output byte 1 sits at `payload[55:48]` and output byte 7 at `payload[7:0]`. Output bytes 1 to 4 come from line bytes 11 to 14, output byte 5 from line byte 5, output byte 6 from line byte 15, and output byte 7 is 8'hFF. In each output byte, bit 7 holds the earliest received bit of its source byte.
- R7: The clock edge that samples an accepted `line_start` sets `davn_n` to 1.
- R8: If `host_busy` is 1 in the cycle in which a clean line completes, no store takes place. `payload` and `davn_n` keep their values, and `payload` never changes without a store.
- R9: An accepted `line_start` in the middle of a line discards the partial line and starts again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_en | input | 1 | One-cycle strobe marking a valid half-bit sample |
| half_dat | input | 1 | Sliced data level of the current half-bit |
| line_start | input | 1 | One-cycle strobe at the start of a video line |
| line16 | input | 1 | High while the line carrying the label data is in progress |
| host_busy | input | 1 | High while the host bus is accessing the transfer word |
| payload | output | 56 | Transfer word, output byte 1 in the top byte |
| store | output | 1 | One-cycle pulse when the transfer word is updated |
| davn_n | output | 1 | Data-available flag, active low |

## Verification
The two events that can fall in the same cycle are the completion of a clean line and a host access holding the inhibit. The bench raises `host_busy` before the final half-bit and holds it until well after the completion instant, which is two clocks after the last half-bit strobe. It then checks that no store pulse appears, that `davn_n` stays at the high level set by the line start, and that the payload still holds the previous word. The next clean line, sent with the inhibit low, must update the word and lower `davn_n`, which shows that the inhibit does not hold the decoder in a stuck state.

// File: rtl/vpsd_pkg.sv
package vpsd_pkg;

  localparam int OUT_BYTES = 7;
  localparam int PAY_W     = OUT_BYTES * 8;

  // Line byte (1-based) feeding each output slot; 0 means a slot filled with ones.
  function automatic int src_line_byte(input int slot);
    case (slot)
      0:       return 11;
      1:       return 12;
      2:       return 13;
      3:       return 14;
      4:       return 5;
      5:       return 15;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

endpackage

// File: rtl/vpsd_halfbit_pair.sv
module vpsd_halfbit_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic accept,
  input  logic half_en,
  input  logic half_dat,
  output logic bit_vld,
  output logic bit_val,
  output logic bit_err
);

  logic have_q, have_d;
  logic first_q, first_d;
  logic vld_d, val_d, err_d;

  always_comb begin
    have_d  = have_q;
    first_d = first_q;
    vld_d   = 1'b0;
    val_d   = bit_val;
    err_d   = bit_err;
    if (clear) begin
      have_d = 1'b0;
    end else if (half_en && accept) begin
      if (!have_q) begin
        have_d  = 1'b1;
        first_d = half_dat;
      end else begin
        have_d = 1'b0;
        vld_d  = 1'b1;
        val_d  = first_q;
        err_d  = (first_q == half_dat);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
      bit_err <= 1'b0;
    end else begin
      have_q  <= have_d;
      first_q <= first_d;
      bit_vld <= vld_d;
      bit_val <= val_d;
      bit_err <= err_d;
    end
  end

  AST_PAIR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> !have_q) else $error("bit emitted with half-bit pending"); // R3

  AST_BIT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(half_en)) else $error("bit emitted without half-bit strobe"); // R3

endmodule

// File: rtl/vpsd_frame_track.sv
module vpsd_frame_track #(
  parameter int                    LINE_BYTES = 15,
  parameter int                    SYNC_BITS  = 24,
  parameter logic [SYNC_BITS-1:0]  SYNC_WORD  = 24'h515555,
  localparam int                   TOTAL_BITS = LINE_BYTES * 8,
  localparam int                   CNT_W      = $clog2(TOTAL_BITS + 1),
  localparam int                   NUM_W      = $clog2(LINE_BYTES + 1),
  localparam int                   SW_W       = (SYNC_BITS > 1) ? $clog2(SYNC_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             abort,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             bit_err,
  output logic             running,
  output logic             byte_we,
  output logic [NUM_W-1:0] byte_num,
  output logic [7:0]       byte_dat,
  output logic             done,
  output logic             done_ok
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d;
  logic             err_q, err_d;
  logic [6:0]       sr_q, sr_d;
  logic             we_d, done_d, ok_d;
  logic [NUM_W-1:0] num_d;
  logic [7:0]       dat_d;
  logic             take, last, in_sync, sync_ref, sync_bad;
  logic [SYNC_BITS-1:0] sync_vec;

  assign sync_vec = SYNC_WORD;
  assign take     = bit_vld && running && !restart && !abort;
  assign last     = (cnt_q == CNT_W'(TOTAL_BITS - 1));
  assign in_sync  = (cnt_q < CNT_W'(SYNC_BITS));
  assign sync_ref = sync_vec[cnt_q[SW_W-1:0]];
  assign sync_bad = in_sync && (bit_val != sync_ref);

  always_comb begin
    run_d  = running;
    cnt_d  = cnt_q;
    err_d  = err_q;
    sr_d   = sr_q;
    we_d   = 1'b0;
    num_d  = byte_num;
    dat_d  = byte_dat;
    done_d = 1'b0;
    ok_d   = done_ok;
    if (restart) begin
      run_d = 1'b1;
      cnt_d = '0;
      err_d = 1'b0;
    end else if (abort) begin
      run_d = 1'b0;
    end else if (take) begin
      err_d = err_q | bit_err | sync_bad;
      sr_d  = {bit_val, sr_q[6:1]};
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q[2:0] == 3'd7) begin
        we_d  = 1'b1;
        num_d = NUM_W'(cnt_q >> 3) + NUM_W'(1);
        dat_d = {bit_val, sr_q};
      end
      if (last) begin
        run_d  = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
        ok_d   = !(err_q | bit_err | sync_bad);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      sr_q     <= '0;
      byte_we  <= 1'b0;
      byte_num <= '0;
      byte_dat <= '0;
      done     <= 1'b0;
      done_ok  <= 1'b0;
    end else begin
      running  <= run_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      sr_q     <= sr_d;
      byte_we  <= we_d;
      byte_num <= num_d;
      byte_dat <= dat_d;
      done     <= done_d;
      done_ok  <= ok_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(TOTAL_BITS)) else $error("bit counter past line length"); // R4

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(running)) else $error("line completion outside a line"); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("line completion repeated"); // R5

endmodule

// File: rtl/vpsd_payload_map.sv
module vpsd_payload_map #(
  parameter  int LINE_BYTES = 15,
  localparam int NUM_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_we,
  input  logic [NUM_W-1:0]           byte_num,
  input  logic [7:0]                 byte_dat,
  input  logic                       commit,
  output logic [vpsd_pkg::PAY_W-1:0] payload
);

  localparam int NB = vpsd_pkg::OUT_BYTES;

  logic [vpsd_pkg::PAY_W-1:0] image;
  logic [vpsd_pkg::PAY_W-1:0] pay_d;

  for (genvar k = 0; k < NB; k++) begin : g_slot
    localparam int SRC = vpsd_pkg::src_line_byte(k);
    if (SRC == 0) begin : g_fill
      assign image[(NB-1-k)*8 +: 8] = 8'hFF;
    end else begin : g_cap
      logic [7:0] stage_q, stage_d;
      always_comb begin
        stage_d = stage_q;
        if (byte_we && (byte_num == NUM_W'(SRC))) stage_d = byte_dat;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 8'hFF;
        else        stage_q <= stage_d;
      end
      assign image[(NB-1-k)*8 +: 8] = vpsd_pkg::bit_rev8(stage_d);
    end
  end

  always_comb begin
    pay_d = payload;
    if (commit) pay_d = image;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) payload <= '1;
    else        payload <= pay_d;
  end

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(payload) |-> $past(commit)) else $error("payload changed without commit"); // R8

endmodule

// File: rtl/vps_line_decoder.sv
module vps_line_decoder #(
  parameter  int                   LINE_BYTES = 15,
  parameter  int                   SYNC_BITS  = 24,
  parameter  logic [SYNC_BITS-1:0] SYNC_WORD  = 24'h515555,
  localparam int                   NUM_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       half_en,
  input  logic                       half_dat,
  input  logic                       line_start,
  input  logic                       line16,
  input  logic                       host_busy,
  output logic [vpsd_pkg::PAY_W-1:0] payload,
  output logic                       store,
  output logic                       davn_n
);

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             restart, abort, running;
  logic             bit_vld, bit_val, bit_err;
  logic             byte_we, done, done_ok;
  logic [NUM_W-1:0] byte_num;
  logic [7:0]       byte_dat;
  logic             store_go, davn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign restart  = line_start && line16;
  assign abort    = !line16;
  assign store_go = done && done_ok && !host_busy && !restart;

  vpsd_halfbit_pair u_pair (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clear    (restart || abort),
    .accept   (running && line16),
    .half_en  (half_en),
    .half_dat (half_dat),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .bit_err  (bit_err)
  );

  vpsd_frame_track #(
    .LINE_BYTES (LINE_BYTES),
    .SYNC_BITS  (SYNC_BITS),
    .SYNC_WORD  (SYNC_WORD)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .restart  (restart),
    .abort    (abort),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .bit_err  (bit_err),
    .running  (running),
    .byte_we  (byte_we),
    .byte_num (byte_num),
    .byte_dat (byte_dat),
    .done     (done),
    .done_ok  (done_ok)
  );

  vpsd_payload_map #(
    .LINE_BYTES (LINE_BYTES)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .byte_we  (byte_we),
    .byte_num (byte_num),
    .byte_dat (byte_dat),
    .commit   (store_go),
    .payload  (payload)
  );

  always_comb begin
    davn_d = davn_n;
    if (restart)       davn_d = 1'b1;
    else if (store_go) davn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      store  <= 1'b0;
      davn_n <= 1'b1;
    end else begin
      store  <= store_go;
      davn_n <= davn_d;
    end
  end

  AST_START_RAISES_DAVN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (line_start && line16) |=> davn_n) else $error("davn_n not raised at line start"); // R7

  AST_DAVN_FALL_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(davn_n) |-> store) else $error("davn_n fell without store"); // R5

  AST_STORE_LOWERS_DAVN: assert property (@(posedge clk) disable iff (!rst_i_n)
    store |-> !davn_n) else $error("store without davn_n low"); // R5

  AST_NO_STORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    store |-> $past(!host_busy)) else $error("store during host access"); // R8

  AST_STORE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_i_n)
    store |-> $past(line16)) else $error("store outside line 16"); // R2

endmodule

// File: tb/vps_line_decoder_test.sv
module vps_line_decoder_test;

  localparam logic [23:0] SYNC = 24'h515555;
  localparam int NV = 10;

  // Tail bytes 4..15 of each line, bit i = (24+i)-th received bit.
  localparam logic [95:0] T_TAIL [NV] = '{
    96'h0123_4567_89AB_CDEF_1122_3344,
    96'h0F1E_2D3C_4B5A_6978_8796_A5B4,
    96'hFEDC_BA98_7654_3210_A5A5_5A5A,
    96'hDEAD_BEEF_CAFE_F00D_1357_9BDF,
    96'hDEAD_BEEF_CAFE_F00D_1357_9BDF,
    96'h0F1E_2D3C_4B5A_6978_8796_A5B4,
    96'hDEAD_BEEF_CAFE_F00D_1357_9BDF,
    96'h0123_4567_89AB_CDEF_1122_3344,
    96'h0123_4567_89AB_CDEF_1122_3344,
    96'hFEDC_BA98_7654_3210_A5A5_5A5A
  };
  localparam int T_ERR [NV] = '{-1, -1, -1, 50, -1, -1, -1, 119, 5, -1};
  // {bad_sync, busy_at_end, gate, expect_store}
  localparam logic [3:0] T_FLG [NV] = '{
    4'b0011, 4'b0000, 4'b0011, 4'b0010, 4'b1010,
    4'b0110, 4'b0011, 4'b0010, 4'b0010, 4'b0011
  };

  logic        clk = 1'b0;
  logic        rst_n, half_en, half_dat, line_start, line16, host_busy;
  logic [55:0] payload;
  logic        store, davn_n;

  int tests = 0, fails = 0, stores = 0;
  bit finished = 1'b0;
  logic [55:0] exp_pay;
  logic        exp_davn;

  always #4 clk = ~clk;

  vps_line_decoder uut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .half_dat(half_dat),
    .line_start(line_start), .line16(line16), .host_busy(host_busy),
    .payload(payload), .store(store), .davn_n(davn_n)
  );

  always @(negedge clk) if (store) stores++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [55:0] map_line(input logic [119:0] f);
    int src [7] = '{11, 12, 13, 14, 5, 15, 0};
    logic [55:0] o = '1;
    for (int k = 0; k < 7; k++)
      if (src[k] != 0)
        for (int j = 0; j < 8; j++) o[(6-k)*8 + 7 - j] = f[(src[k]-1)*8 + j];
    return o;
  endfunction

  task automatic send_bits(input logic [119:0] f, input int errbit,
                           input bit busy, input int n);
    for (int i = 0; i < n; i++) begin
      if (busy && i == n - 1) host_busy = 1'b1;
      half_en = 1'b1; half_dat = f[i];
      @(negedge clk); half_en = 1'b0;
      @(negedge clk);
      half_en = 1'b1; half_dat = (i == errbit) ? f[i] : ~f[i];
      @(negedge clk); half_en = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    host_busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_line(input bit gate);
    line16 = gate; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    if (gate) chk(davn_n === 1'b1, "R7", "davn_n after line start", davn_n, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; half_en = 1'b0; half_dat = 1'b0;
    line_start = 1'b0; line16 = 1'b0; host_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk(davn_n === 1'b1, "R1", "reset davn_n", davn_n, 1'b1);
    chk(store === 1'b0, "R1", "reset store", store, 1'b0);
    chk(payload === '1, "R1", "reset payload", payload, {56{1'b1}});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_pay = '1; exp_davn = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [119:0] full;
      int s0;
      full = {T_TAIL[v], SYNC};
      if (T_FLG[v][3]) full[20] = ~full[20];
      s0 = stores;
      start_line(T_FLG[v][1]);
      send_bits(full, T_ERR[v], T_FLG[v][2], 120);
      if (T_FLG[v][1]) exp_davn = !T_FLG[v][0];
      if (T_FLG[v][0]) exp_pay = map_line(full);
      // R3 biphase errors, R4 sync, R5 store pulse, R8 inhibit, R2 gate
      chk(stores - s0 == int'(T_FLG[v][0]), T_FLG[v][0] ? "R5" : "R3_R4_R8_R2",
          $sformatf("vector %0d store count", v), stores - s0, T_FLG[v][0]);
      chk(davn_n === exp_davn, "R5", $sformatf("vector %0d davn_n", v), davn_n, exp_davn);
      chk(payload === exp_pay, "R6", $sformatf("vector %0d payload", v), payload, exp_pay);
    end

    // R9: restart mid-line discards the partial line
    begin
      logic [119:0] fa, fb;
      int s0;
      fa = {T_TAIL[0], SYNC}; fb = {T_TAIL[2], SYNC};
      s0 = stores;
      start_line(1'b1);
      send_bits(fb, -1, 1'b0, 60);
      start_line(1'b1);
      send_bits(fa, -1, 1'b0, 120);
      exp_pay = map_line(fa);
      chk(stores - s0 == 1, "R9", "restart store count", stores - s0, 1);
      chk(payload === exp_pay, "R9", "restart payload", payload, exp_pay);
    end

    // R2: stray half-bits with no accepted line start
    begin
      int s0;
      s0 = stores;
      send_bits({T_TAIL[1], SYNC}, -1, 1'b0, 120);
      chk(stores == s0, "R2", "stray bits store count", stores - s0, 0);
      chk(payload === exp_pay, "R2", "stray bits payload", payload, exp_pay);
      chk(davn_n === 1'b0, "R2", "stray bits davn_n", davn_n, 1'b0);
    end

    // R2: gate drops in the middle of a line
    begin
      logic [119:0] fc;
      int s0;
      fc = {T_TAIL[1], SYNC};
      s0 = stores;
      start_line(1'b1);
      send_bits(fc, -1, 1'b0, 60);
      line16 = 1'b0; repeat (2) @(negedge clk); line16 = 1'b1;
      send_bits(fc, -1, 1'b0, 120);
      chk(stores == s0, "R2", "aborted line store count", stores - s0, 0);
      chk(davn_n === 1'b1, "R2", "aborted line davn_n", davn_n, 1'b1);
      chk(payload === exp_pay, "R2", "aborted line payload", payload, exp_pay);
    end

    // R1: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    chk(davn_n === 1'b1, "R1", "mid reset davn_n", davn_n, 1'b1);
    chk(payload === '1, "R1", "mid reset payload", payload, {56{1'b1}});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule